// File: doc/BRIEF.md
# SMBus Slave Receiver with Host-Decided Acknowledge

This block is the receiving half of an SMBus/I2C slave. It watches the open-drain SDA and SCL lines, recognises START and STOP conditions, and shifts in an address byte. When the 7-bit address matches the programmed slave address and the direction bit asks for a write, it then shifts in data bytes. The block never decides an acknowledge by itself. After each accepted byte it raises an interrupt and sets an acknowledge-request flag. It then stretches the clock until the host answers.

The host reads the received byte. It places its decision on `ack_bit` (1 = ACK, 0 = NACK) and pulses `irq_clr`. The block then lets SCL go. It pulls SDA low through the ninth clock only when the decision was ACK. If the host NACKs the address, the block ignores all traffic until the next START. A host write strobe on the data register while receiving is reported as a switch to transmit mode. The transmit shifter itself is not part of this block.

Top module: `smb_slave_rx`

## Requirements
- R1: After reset both pull-low outputs are inactive, and `irq`, `ack_req`, `rx_mode` and `tx_mode` are all 0.
- R2: A START followed by the programmed 7-bit address and a direction bit of 0 (write), with `inhibit` = 0, raises `irq` and `ack_req` and sets `rx_mode`. At that point `rx_data` holds the address byte, with the address in bits 7:1 and the direction bit in bit 0.
- R3: When the address differs, when the direction bit is 1, or when `inhibit` = 1, no interrupt is raised. SDA stays released during the ninth clock, so the master sees a NACK.
- R4: While `irq` is pending after a byte, SCL is held low once it has fallen. SCL is released as soon as the host pulses `irq_clr`.
- R5: The value of `ack_bit` at the `irq_clr` pulse decides the ninth clock. With 1, SDA is held low for that clock. With 0, SDA is left released.
- R6: After the host NACKs the address, further data clocks raise no interrupt and receive no ACK. The next START restores normal address matching.
- R7: Each data byte after an ACKed address is received MSB first. It raises `irq` and `ack_req` after its eighth bit and before the ninth clock rises, and its value appears on `rx_data`.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle, with `rx_mode` and `tx_mode` both 0.
- R9: A `dat_wr` pulse while `rx_mode` is 1 sets `tx_mode` and clears `rx_mode`. A `dat_wr` pulse outside receiver mode leaves `tx_mode` at 0.
- R10: A repeated START in the middle of a transfer restarts address reception. A matching write address then raises a new address interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 7 | Programmed slave address |
| inhibit | input | 1 | 1 = ignore slave addresses |
| ack_bit | input | 1 | Host decision, 1 = ACK, 0 = NACK |
| irq_clr | input | 1 | Host pulse: clear interrupt, commit `ack_bit` |
| dat_wr | input | 1 | Host write strobe to the data register |
| irq | output | 1 | Byte-received interrupt |
| ack_req | output | 1 | Acknowledge decision requested |
| rx_data | output | 8 | Last received byte |
| rx_mode | output | 1 | Receiver mode active |
| tx_mode | output | 1 | Host switched the transfer to transmit |

## Verification
The bench runs random transfers that mix matching and foreign addresses, read direction, `inhibit`, and per-byte host ACK/NACK choices. Directed cases cover a repeated START, data strobes inside and outside receiver mode, and data clocked after a NACKed address. A design that took the interrupt after the ninth clock, or that failed to stretch, would let the master sample SDA before the host answered, so the acknowledge would not match the host's choice. A design that forgot the NACK lockout would raise interrupts for the stray bytes. A design that mis-ordered bits, or checked the direction bit wrongly, would show a wrong `rx_data` or accept reads.

// File: rtl/smb_slave_rx.sv
module smb_slave_rx #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              inhibit,
  input  logic              ack_bit,
  input  logic              irq_clr,
  input  logic              dat_wr,
  output logic              irq,
  output logic              ack_req,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_mode,
  output logic              tx_mode
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD, S_ACKB, S_BLOCK} st_t;
  st_t state;

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic is_addr, low_seen, ack_l, ack_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
    end
  end

  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire last_bit = (cnt == CNT_W'(BYTE_W - 1));
  wire [BYTE_W-1:0] full = {shreg[BYTE_W-2:0], sda_s};
  wire addr_ok  = !inhibit && full[BYTE_W-1:1] == own_addr && !full[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      is_addr  <= 1'b0;
      low_seen <= 1'b0;
      ack_l    <= 1'b0;
      ack_rise <= 1'b0;
      irq      <= 1'b0;
      ack_req  <= 1'b0;
      rx_data  <= '0;
      rx_mode  <= 1'b0;
      tx_mode  <= 1'b0;
    end else if (start_c) begin
      state    <= S_ADDR;
      cnt      <= '0;
      low_seen <= 1'b0;
      ack_rise <= 1'b0;
      rx_mode  <= 1'b0;
      tx_mode  <= 1'b0;
    end else if (stop_c) begin
      state   <= S_IDLE;
      rx_mode <= 1'b0;
      tx_mode <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_DATA: if (scl_rise) begin
          shreg <= full;
          cnt   <= cnt + CNT_W'(1);
          if (last_bit) begin
            cnt      <= '0;
            low_seen <= 1'b0;
            is_addr  <= (state == S_ADDR);
            if ((state == S_ADDR) ? addr_ok : rx_mode) begin
              irq     <= 1'b1;
              ack_req <= 1'b1;
              rx_data <= full;
              state   <= S_HOLD;
              if (state == S_ADDR) rx_mode <= 1'b1;
            end else begin
              state <= S_BLOCK;
            end
          end
        end
        S_HOLD: begin
          if (scl_fall) low_seen <= 1'b1;
          if (irq_clr) begin
            irq      <= 1'b0;
            ack_req  <= 1'b0;
            ack_l    <= ack_bit;
            ack_rise <= 1'b0;
            state    <= S_ACKB;
          end
        end
        S_ACKB: begin
          if (scl_fall && !low_seen) low_seen <= 1'b1;
          if (scl_rise && low_seen) ack_rise <= 1'b1;
          if (scl_fall && ack_rise) begin
            cnt <= '0;
            if (is_addr && !ack_l) begin
              state   <= S_BLOCK;
              rx_mode <= 1'b0;
            end else begin
              state <= S_DATA;
            end
          end
        end
        default: ;
      endcase
      if (dat_wr && rx_mode) begin
        tx_mode <= 1'b1;
        rx_mode <= 1'b0;
      end
    end
  end

  assign scl_pull = (state == S_HOLD) & irq & low_seen;
  assign sda_pull = (state == S_ACKB) & ack_l & low_seen;
endmodule

module smb_slave_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_pull,
  input logic sda_pull,
  input logic irq,
  input logic ack_req,
  input logic rx_mode,
  input logic tx_mode
);
  // R4
  stretch_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> irq);
  // R5
  ack_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> !irq);
  // R5
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  // R2
  req_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> irq);
  // R7
  irq_in_rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> rx_mode);
  // R9
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_mode && rx_mode));
endmodule

bind smb_slave_rx smb_slave_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_pull(scl_pull),
  .sda_pull(sda_pull), .irq(irq), .ack_req(ack_req),
  .rx_mode(rx_mode), .tx_mode(tx_mode)
);

// File: tb/smb_slave_rx_bench.sv
module smb_slave_rx_bench;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int H = 20;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic inhibit = 0, ack_bit = 0, irq_clr = 0, dat_wr = 0;
  logic scl_pull, sda_pull, irq, ack_req, rx_mode, tx_mode;
  logic [7:0] rx_data;
  wire scl_line = scl_m & ~scl_pull;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0, irq_cnt = 0, hidx = 0;
  bit done = 0;
  logic [7:0] exp_byte [0:7];
  bit ack_plan [0:7];

  always #2 clk = ~clk;

  smb_slave_rx u_smb_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
    .inhibit(inhibit), .ack_bit(ack_bit), .irq_clr(irq_clr), .dat_wr(dat_wr),
    .irq(irq), .ack_req(ack_req), .rx_data(rx_data),
    .rx_mode(rx_mode), .tx_mode(tx_mode));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit accepted(input logic [6:0] a, input bit rw, input bit inh);
    return (a == OWN) && !rw && !inh;
  endfunction

  task automatic hw(input int n = H);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1; hw(); scl_m = 1; wait_scl_high(); hw();
    sda_m = 0; hw(); scl_m = 0; hw();
  endtask

  task automatic m_stop();
    sda_m = 0; hw(); scl_m = 1; wait_scl_high(); hw();
    sda_m = 1; hw(); hw();
  endtask

  task automatic m_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl_m = 1; wait_scl_high(); hw(); scl_m = 0; hw();
    end
  endtask

  task automatic m_ack(output bit nack);
    sda_m = 1; hw(); scl_m = 1; wait_scl_high(); hw(H/2);
    nack = sda_line; hw(H/2); scl_m = 0; hw();
  endtask

  // host model: answers each interrupt from the plan arrays
  initial forever begin
    @(negedge clk);
    if (irq === 1'b1) begin
      irq_cnt++;
      hw(60);
      chk(scl_line == 0, "R4 stretch", scl_line, 0);
      chk(ack_req == 1, "R7 ack_req", ack_req, 1);
      chk(rx_data == exp_byte[hidx], "R7 rx_data", rx_data, exp_byte[hidx]);
      chk(rx_mode == 1, "R2 rx_mode", rx_mode, 1);
      ack_bit = ack_plan[hidx];
      hidx++;
      irq_clr = 1; @(negedge clk); irq_clr = 0;
    end
  end

  task automatic xfer(input logic [6:0] a, input bit rw, input bit inh,
                      input int nb, input bit a_ack);
    bit nack, acc, exp_n;
    int base, exp_irq;
    inhibit = inh; hidx = 0; base = irq_cnt;
    exp_byte[0] = {a, rw}; ack_plan[0] = a_ack;
    for (int i = 1; i <= nb; i++) begin
      exp_byte[i] = 8'($urandom);
      ack_plan[i] = ($urandom % 4) != 0;
    end
    acc = accepted(a, rw, inh);
    m_start();
    m_byte({a, rw});
    m_ack(nack);
    exp_n = !(acc && a_ack);
    chk(nack == exp_n, acc ? "R5 address ack" : "R3 ignored address", nack, exp_n);
    exp_irq = acc ? 1 : 0;
    for (int i = 1; i <= nb; i++) begin
      m_byte(exp_byte[i]);
      m_ack(nack);
      if (acc && a_ack) begin
        exp_irq++;
        chk(nack == !ack_plan[i], "R5 data ack", nack, !ack_plan[i]);
        if (!ack_plan[i]) break;
      end else begin
        chk(nack == 1, "R6 locked out", nack, 1);
      end
    end
    m_stop();
    chk(irq_cnt - base == exp_irq, acc ? "R7 irq count" : "R3 irq count",
        irq_cnt - base, exp_irq);
    chk(rx_mode == 0 && tx_mode == 0, "R8 idle after stop", {rx_mode, tx_mode}, 0);
  endtask

  initial begin
    bit nack;
    int base;
    void'($urandom(32'd7741));
    hw(5); rst_n = 1; hw(3);
    chk(scl_pull == 0 && sda_pull == 0, "R1 pulls", {scl_pull, sda_pull}, 0);
    chk(irq == 0 && ack_req == 0, "R1 flags", {irq, ack_req}, 0);
    chk(rx_mode == 0 && tx_mode == 0, "R1 modes", {rx_mode, tx_mode}, 0);

    xfer(OWN, 0, 0, 2, 1);
    xfer(OWN, 0, 0, 1, 0);
    xfer(OWN ^ 7'h01, 0, 0, 1, 1);
    xfer(OWN, 1, 0, 0, 1);
    xfer(OWN, 0, 1, 1, 1);

    // R9: strobe outside receiver mode is ignored
    dat_wr = 1; @(negedge clk); dat_wr = 0; hw(2);
    chk(tx_mode == 0, "R9 idle strobe", tx_mode, 0);

    // R10: repeated start, then R9 strobe inside receiver mode
    hidx = 0; inhibit = 0;
    exp_byte[0] = {OWN, 1'b0}; ack_plan[0] = 1;
    exp_byte[1] = 8'hC3;       ack_plan[1] = 1;
    exp_byte[2] = {OWN, 1'b0}; ack_plan[2] = 1;
    base = irq_cnt;
    m_start(); m_byte({OWN, 1'b0}); m_ack(nack);
    m_byte(8'hC3); m_ack(nack);
    m_start(); m_byte({OWN, 1'b0}); m_ack(nack);
    chk(irq_cnt - base == 3, "R10 repeated start irq", irq_cnt - base, 3);
    chk(nack == 0, "R10 address acked", nack, 0);
    dat_wr = 1; @(negedge clk); dat_wr = 0; hw(2);
    chk(tx_mode == 1 && rx_mode == 0, "R9 switch to tx", {tx_mode, rx_mode}, 2);
    m_stop();
    chk(tx_mode == 0, "R8 stop clears tx", tx_mode, 0);

    for (int t = 0; t < 25; t++) begin
      logic [6:0] a;
      a = ($urandom % 3 != 0) ? OWN : 7'($urandom);
      xfer(a, ($urandom % 5) == 0, ($urandom % 6) == 0,
           int'($urandom % 4), ($urandom % 4) != 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule